// File: doc/BRIEF.md
# I2C Crosspoint Switch Controller

This block is the control side of a video crosspoint with six inputs and eight outputs. It listens as a write-only slave on a two-wire I2C bus. It holds, as registered control vectors, the routing and the per-channel settings that the analog switch fabric consumes. SCL and SDA are oversampled on a fast system clock. The slave pulls SDA low through an open-drain enable to acknowledge its address and every data byte.

A transfer carries a sequence of bytes, and bit 0 of each byte says what it is. A pointer byte picks one of the eight outputs. A settings byte then loads the input select, gain, drive state and mixer enable of that output, and it also loads the clamp mode of the input that the same byte names.

Two address bits come from a strapping input, so up to four controllers can share one bus. After reset every output floats and every input is clamped.

Top module: `xbar_i2c_ctrl`

## Requirements
- R1: After reset, every bit of `tristate_o` and `clamp_o` is 1, and `in_sel_o`, `gain_o` and `mix_en_o` are all 0.
- R2: The slave address is binary 1001 0, then `sub_addr_i[1]`, then `sub_addr_i[0]`, then a R/W bit of 0. A matching address byte is acknowledged (SDA held low during the ninth SCL high). A mismatched address is not acknowledged, and the bytes that follow it in that transfer change nothing.
- R3: An address byte whose R/W bit (bit 0) is 1 is not acknowledged and changes nothing.
- R4: After a matched address, every data byte is acknowledged. A data byte with bit 0 = 0 is a pointer byte: its bits 7..5 select the output, with codes 0..7 standing for OUT1..OUT8.
- R5: A data byte with bit 0 = 1 is a settings byte for the pointed output k (0-based). Bits 7..5 are written to `in_sel_o[3k+2:3k]` (codes 0..5 stand for IN1..IN6). Bit 3 is written to `gain_o[k]` (1 = high gain). Bit 1 is written to `tristate_o[k]` (1 = high impedance).
- R6: Bit 4 of a settings byte is written to `clamp_o[c]`, where c is the input code in bits 7..5 of that same byte (1 = clamped).
- R7: In a settings byte with input code 6 or 7, the routing and all clamp bits stay unchanged, while gain and drive state are still written.
- R8: Bit 2 of a settings byte is stored in `mix_en_o[0]` when the pointer is OUT7 and in `mix_en_o[1]` when it is OUT8. For any other output, that bit is ignored.
- R9: A STOP, or a repeated START, returns the slave to address reception. Bytes that follow a repeated START carrying a foreign address change nothing.
- R10: Registers change only when a complete data byte has been received. A byte cut short by a STOP has no effect.
- R11: The pointer persists over several settings bytes and across transfers until the next pointer byte arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sub_addr_i | input | 2 | Strapped low two bits of the slave address |
| sda_oe_o | output | 1 | Pull SDA low when 1 (acknowledge) |
| in_sel_o | output | 24 | Input code per output, 3 bits each, OUT1 in bits 2:0 |
| gain_o | output | 8 | High gain per output |
| tristate_o | output | 8 | High impedance per output |
| mix_en_o | output | 2 | Mixer select for OUT7 (bit 0) and OUT8 (bit 1) |
| clamp_o | output | 6 | Clamp mode per input, IN1 in bit 0 |

## Verification
The hardest states to reach are the ones where the bus is abandoned part of the way through: a STOP that lands in the middle of a settings byte, and a repeated START that switches to a foreign address after a pointer has already been loaded. The bench drives both at bit level with an open-drain bus model. It leaves a partial byte and then issues a STOP. It also loads a pointer, re-addresses a different device and sends a settings byte that must be dropped. A later transfer with no pointer byte then shows that the earlier pointer survived.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int unsigned N_IN   = 6;
  localparam int unsigned N_OUT  = 8;
  localparam int unsigned N_MIX  = 2;
  localparam int unsigned SEL_W  = $clog2(N_IN);
  localparam int unsigned PTR_W  = $clog2(N_OUT);
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W) + 1;
  localparam logic [4:0]  ADDR_HI = 5'b10010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_DATA, ST_DATA_ACK
  } rx_st_e;
endpackage

// File: rtl/xbar_i2c_sync.sv
module xbar_i2c_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign scl_o      = scl_ff[1];
  assign sda_o      = sda_ff[1];
  assign scl_rise_o = scl_ff[1] & ~scl_q;
  assign scl_fall_o = ~scl_ff[1] & scl_q;
  // SDA edges while SCL stays high
  assign start_o    = scl_ff[1] & scl_q & sda_q & ~sda_ff[1];
  assign stop_o     = scl_ff[1] & scl_q & ~sda_q & sda_ff[1];
endmodule

// File: rtl/xbar_i2c_rx.sv
module xbar_i2c_rx
  import xbar_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [1:0]        sub_addr_i,
  output logic              sda_oe_o,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o
);
  rx_st_e            st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              full;
  logic [BYTE_W-1:0] my_addr;

  assign full    = (cnt_q == CNT_W'(BYTE_W));
  assign my_addr = {ADDR_HI, sub_addr_i, 1'b0};
  assign byte_o  = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      sda_oe_o   <= 1'b0;
      byte_vld_o <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      if (start_i) begin
        st_q     <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        st_q     <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_DATA: begin
            if (scl_rise_i && !full) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_s_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && full) begin
              if (st_q == ST_DATA) begin
                byte_vld_o <= 1'b1;
                sda_oe_o   <= 1'b1;
                st_q       <= ST_DATA_ACK;
              end else if (sh_q == my_addr) begin
                sda_oe_o <= 1'b1;
                st_q     <= ST_ADDR_ACK;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK, ST_DATA_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              cnt_q    <= '0;
              st_q     <= ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // acknowledge is only ever applied while SCL is low
  assert_ack_scl_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s_i);
  assert_no_read_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ADDR && scl_fall_i && full && sh_q[0] && !start_i && !stop_i) |=> !sda_oe_o);
  assert_stop_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!sda_oe_o && st_q == ST_IDLE));
  assert_vld_acked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> (sda_oe_o && st_q == ST_DATA_ACK));
endmodule

// File: rtl/xbar_regs.sv
module xbar_regs
  import xbar_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   byte_vld_i,
  input  logic [BYTE_W-1:0]      byte_i,
  output logic [N_OUT*SEL_W-1:0] in_sel_o,
  output logic [N_OUT-1:0]       gain_o,
  output logic [N_OUT-1:0]       tristate_o,
  output logic [N_MIX-1:0]       mix_en_o,
  output logic [N_IN-1:0]        clamp_o
);
  localparam logic [SEL_W-1:0] IN_LIM = SEL_W'(N_IN);

  logic [PTR_W-1:0]                ptr_q;
  logic [N_OUT-1:0][SEL_W-1:0]     sel_q;
  logic [SEL_W-1:0]                code;
  logic                            set_wr;
  logic                            code_ok;

  assign code    = byte_i[BYTE_W-1 -: SEL_W];
  assign set_wr  = byte_vld_i & byte_i[0];
  assign code_ok = (code < IN_LIM);
  assign in_sel_o = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ptr_q <= '0;
    else if (byte_vld_i && !byte_i[0]) ptr_q <= byte_i[BYTE_W-1 -: PTR_W];
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sel_q[o]      <= '0;
        gain_o[o]     <= 1'b0;
        tristate_o[o] <= 1'b1;
      end else if (set_wr && ptr_q == PTR_W'(o)) begin
        if (code_ok) sel_q[o] <= code;
        gain_o[o]     <= byte_i[3];
        tristate_o[o] <= byte_i[1];
      end
    end
    assert_sel_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_q[o] < IN_LIM);
  end

  for (genvar m = 0; m < N_MIX; m++) begin : g_mix
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          mix_en_o[m] <= 1'b0;
      else if (set_wr && ptr_q == PTR_W'(N_OUT - N_MIX + m)) mix_en_o[m] <= byte_i[2];
    end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             clamp_o[i] <= 1'b1;
      else if (set_wr && code == SEL_W'(i))   clamp_o[i] <= byte_i[4];
    end
  end

  assert_mix_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_wr && ptr_q < PTR_W'(N_OUT - N_MIX)) |=> $stable(mix_en_o));
  assert_hold_no_byte_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_i |=> ($stable(tristate_o) && $stable(gain_o) && $stable(clamp_o) && $stable(in_sel_o)));
  assert_clamp_bad_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_wr && !code_ok) |=> $stable(clamp_o));
endmodule

// File: rtl/xbar_i2c_ctrl.sv
module xbar_i2c_ctrl
  import xbar_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scl_i,
  input  logic                   sda_i,
  input  logic [1:0]             sub_addr_i,
  output logic                   sda_oe_o,
  output logic [N_OUT*SEL_W-1:0] in_sel_o,
  output logic [N_OUT-1:0]       gain_o,
  output logic [N_OUT-1:0]       tristate_o,
  output logic [N_MIX-1:0]       mix_en_o,
  output logic [N_IN-1:0]        clamp_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic byte_vld;
  logic [BYTE_W-1:0] byte_d;

  xbar_i2c_sync u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_p),
    .stop_o     (stop_p)
  );

  xbar_i2c_rx u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_p),
    .stop_i     (stop_p),
    .sub_addr_i (sub_addr_i),
    .sda_oe_o   (sda_oe_o),
    .byte_vld_o (byte_vld),
    .byte_o     (byte_d)
  );

  xbar_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_vld_i (byte_vld),
    .byte_i     (byte_d),
    .in_sel_o   (in_sel_o),
    .gain_o     (gain_o),
    .tristate_o (tristate_o),
    .mix_en_o   (mix_en_o),
    .clamp_o    (clamp_o)
  );

  assert_reset_float_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (&tristate_o && &clamp_o));
endmodule

// File: tb/xbar_i2c_ctrl_bench.sv
module xbar_i2c_ctrl_bench;
  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [1:0]  sub = 2'b00;
  logic        sda_oe;
  logic        sda_line;
  logic [23:0] in_sel;
  logic [7:0]  gain, tri_s;
  logic [1:0]  mix;
  logic [5:0]  clamp;

  logic [23:0] e_sel;
  logic [7:0]  e_gain, e_tri;
  logic [1:0]  e_mix;
  logic [5:0]  e_clamp;
  logic        ack;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  xbar_i2c_ctrl u_xbar_i2c_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sub_addr_i (sub),
    .sda_oe_o   (sda_oe),
    .in_sel_o   (in_sel),
    .gain_o     (gain),
    .tristate_o (tri_s),
    .mix_en_o   (mix),
    .clamp_o    (clamp)
  );

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " in_sel"},   32'(in_sel), 32'(e_sel));
    chk({tag, " gain"},     32'(gain),   32'(e_gain));
    chk({tag, " tristate"}, 32'(tri_s),  32'(e_tri));
    chk({tag, " mix"},      32'(mix),    32'(e_mix));
    chk({tag, " clamp"},    32'(clamp),  32'(e_clamp));
  endtask

  task automatic bus_start();
    sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); wq();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1; wq(); scl_m = 1; wq();
    a = ~sda_line;
    wq(); scl_m = 0; wq();
  endtask

  task automatic t_reset();
    e_sel = '0; e_gain = '0; e_tri = 8'hFF; e_mix = '0; e_clamp = 6'h3F;
    chk_all("R1 reset");
    chk("R1 sda released", 32'(sda_oe), 32'd0);
  endtask

  task automatic t_basic();
    // R4 pointer OUT3, R5/R6 settings IN5 gain high driven, clamp IN5 free
    bus_start();
    send_byte(8'h90, ack); chk("R2 address ack", 32'(ack), 32'd1);
    send_byte(8'h40, ack); chk("R4 pointer ack", 32'(ack), 32'd1);
    send_byte(8'h8D, ack); chk("R4 settings ack", 32'(ack), 32'd1);
    bus_stop();
    e_sel[8:6] = 3'd4; e_gain[2] = 1; e_tri[2] = 0; e_clamp[4] = 0;
    chk_all("R5 R6 basic");
  endtask

  task automatic t_mixer();
    bus_start();
    send_byte(8'h90, ack);
    send_byte(8'hC0, ack);       // OUT7
    send_byte(8'h35, ack);       // IN2, clamp, mix on, driven
    send_byte(8'hE0, ack);       // OUT8
    send_byte(8'h05, ack);       // IN1, free, mix on, driven
    send_byte(8'h20, ack);       // OUT2: mix bit must be ignored
    send_byte(8'h65, ack);       // IN4, free, mix on, driven
    bus_stop();
    e_sel[20:18] = 3'd1; e_tri[6] = 0; e_clamp[1] = 1; e_mix[0] = 1;
    e_sel[23:21] = 3'd0; e_tri[7] = 0; e_clamp[0] = 0; e_mix[1] = 1;
    e_sel[5:3] = 3'd3; e_tri[1] = 0; e_clamp[3] = 0;
    chk_all("R8 mixer");
  endtask

  task automatic t_bad_code();
    bus_start();
    send_byte(8'h90, ack);
    send_byte(8'h00, ack);       // OUT1
    send_byte(8'hE9, ack);       // code 7, clamp 0, gain 1, driven
    bus_stop();
    e_gain[0] = 1; e_tri[0] = 0;
    chk_all("R7 bad code");
  endtask

  task automatic t_addr();
    sub = 2'b11;
    bus_start();
    send_byte(8'h90, ack); chk("R2 foreign nack", 32'(ack), 32'd0);
    send_byte(8'h60, ack);
    send_byte(8'h0B, ack);
    bus_stop();
    chk_all("R2 foreign ignored");
    bus_start();
    send_byte(8'h97, ack); chk("R3 read nack", 32'(ack), 32'd0);
    send_byte(8'h0B, ack);
    bus_stop();
    chk_all("R3 read ignored");
    bus_start();
    send_byte(8'h96, ack); chk("R2 strap ack", 32'(ack), 32'd1);
    send_byte(8'h80, ack);       // OUT5
    send_byte(8'hAB, ack);       // IN6, clamp 0, gain 1, mix 0, tri 1
    bus_stop();
    e_sel[14:12] = 3'd5; e_gain[4] = 1; e_tri[4] = 1; e_clamp[5] = 0;
    chk_all("R2 strap write");
  endtask

  task automatic t_abort();
    bus_start();
    send_byte(8'h96, ack);
    send_byte(8'h00, ack);       // OUT1
    send_bit(1); send_bit(0); send_bit(1); send_bit(1);
    bus_stop();
    chk_all("R10 partial byte");
  endtask

  task automatic t_rep_start();
    bus_start();
    send_byte(8'h96, ack);
    send_byte(8'h20, ack);       // OUT2
    bus_start();
    send_byte(8'h92, ack); chk("R9 restart foreign nack", 32'(ack), 32'd0);
    send_byte(8'h4F, ack);
    bus_stop();
    chk_all("R9 restart ignored");
    bus_start();
    send_byte(8'h96, ack);
    send_byte(8'h49, ack);       // IN3, clamp 0, gain 1, driven -> OUT2
    send_byte(8'h13, ack);       // IN1, clamp 1, gain 0, tri -> OUT2
    bus_stop();
    e_sel[5:3] = 3'd0; e_gain[1] = 0; e_tri[1] = 1; e_clamp[2] = 0; e_clamp[0] = 1;
    chk_all("R11 pointer kept");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset();
    t_basic();
    t_mixer();
    t_bad_code();
    t_addr();
    t_abort();
    t_rep_start();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule